// File: doc/BRIEF.md
# Single-Wire Bus Master Bit-Slot Engine

This block is the timing core of a master on a single-wire, open-drain serial bus with a pull-up. A controller above it gives one command at a time: a bus reset with presence detection, a one-bit write, or a one-bit read. It raises a start strobe with the command, and the engine then produces the low and released intervals of that slot on the line. When the slot is complete, the engine reports with a busy/done handshake. Every duration is a whole number of microseconds. A free-running divider sets the microsecond tick from the parameter `CLKS_PER_US`.

The engine never drives the line high. It controls only an active-high pull-down enable, and it reads the line back through a two-flop synchroniser. The result of a reset is a presence flag, taken at one point inside the slave's answer window. The result of a read is a single bit, taken shortly before the point where the slave's data stops being guaranteed. Both results are held until the next command of the same kind. Byte assembly, command sequencing and the pull-up itself are handled outside this block.

Top module: `owm_slot_engine`

## Requirements
- R1: A reset command (`cmdOp`=2'b00) pulls the line low for exactly RST_LOW_US microseconds (default 500). It then releases the line, and `busy` stays high for RST_LOW_US+RST_HIGH_US microseconds in total (default 1000).
- R2: When a reset is accepted, `presence` is cleared. It is then set to 1 if the synchronised line is low at PRES_SAMPLE_US (default 70) microseconds after the release, and to 0 if the line is high at that point. Commands other than reset leave `presence` unchanged.
- R3: A write command (`cmdOp`=2'b01) pulls the line low for W1_LOW_US (default 6) microseconds when `cmdBit`=1, and for W0_LOW_US (default 65) microseconds when `cmdBit`=0.
- R4: Write and read slots keep `busy` high for SLOT_US+REC_US microseconds (default 70+1). The line is released for the part of that time after the low phase.
- R5: A read command (`cmdOp`=2'b10) pulls the line low for RD_LOW_US (default 2) microseconds. `readBit` then takes the synchronised line level at RD_SAMPLE_US (default 13) microseconds after the falling edge: 1 for released, 0 for held low. The value is held until the next read.
- R6: At the clock edge that accepts a command, `busy` and `busDriveLow` both rise. At the edge where `busy` falls, `done` is high for exactly one clock cycle.
- R7: A `cmdStart` while `busy` is high is ignored, and so is `cmdOp`=2'b11. Neither starts a slot nor changes the running slot's timing.
- R8: After reset, all outputs are 0. `busDriveLow` is 0 (line released) whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Start strobe, sampled on the rising clock edge |
| cmdOp | input | 2 | 00 reset, 01 write, 10 read, 11 reserved |
| cmdBit | input | 1 | Bit value for a write |
| busIn | input | 1 | Raw line level (asynchronous) |
| busDriveLow | output | 1 | 1 enables the open-drain pull-down |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Slave answered the last reset |
| readBit | output | 1 | Bit taken in the last read slot |

## Verification
Each duration is due at an exact cycle count: a phase of N microseconds lasts N*CLKS_PER_US cycles, starting at the accepting edge. The bench therefore counts the cycles in which `busDriveLow` and `busy` are high, and compares the totals with this product. It samples on falling edges, starting with the first falling edge after the accepting edge, and it checks that `done` is seen exactly once and in the cycle where `busy` is first low. The presence and read results are due at the edges that close the programmed sample points, which are two synchroniser cycles behind the line. The modelled slave therefore changes the line several microseconds away from each sample point, and the results are read only after `done`.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } owm_op_e;

  typedef struct packed {
    logic clrTimer;
    logic setLow;
    logic relLow;
    logic clrPresence;
    logic samplePresence;
    logic sampleBit;
  } owm_strobe_t;
endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int MAX_US      = 1000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  owm_strobe_t                   strb,
  input  logic                          busIn,
  output logic                          tick,
  output logic [$clog2(MAX_US+1)-1:0]   usCnt,
  output logic                          busDriveLow,
  output logic                          presence,
  output logic                          readBit
);
  localparam int DW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int UW = $clog2(MAX_US+1);

  logic [DW-1:0] divCnt;
  logic [1:0]    syncQ;
  logic          busSync;

  assign tick    = (divCnt == DW'(CLKS_PER_US-1));
  assign busSync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], busIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (strb.clrTimer) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (tick) begin
      divCnt <= '0;
      usCnt  <= usCnt + UW'(1);
    end else begin
      divCnt <= divCnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busDriveLow <= 1'b0;
      presence    <= 1'b0;
      readBit     <= 1'b0;
    end else begin
      if (strb.setLow)              busDriveLow <= 1'b1;
      else if (strb.relLow)         busDriveLow <= 1'b0;
      if (strb.clrPresence)         presence    <= 1'b0;
      else if (strb.samplePresence) presence    <= ~busSync;
      if (strb.sampleBit)           readBit     <= busSync;
    end
  end

  AST_PRES_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strb.samplePresence |-> !busDriveLow); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleBit |-> !busDriveLow); // R5
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int MAX_US        = 1000,
  parameter int RST_LOW_US    = 500,
  parameter int RST_HIGH_US   = 500,
  parameter int PRES_SAMPLE_US = 70,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 65,
  parameter int RD_LOW_US     = 2,
  parameter int RD_SAMPLE_US  = 13,
  parameter int SLOT_US       = 70,
  parameter int REC_US        = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdStart,
  input  logic [1:0]                  cmdOp,
  input  logic                        cmdBit,
  input  logic                        tick,
  input  logic [$clog2(MAX_US+1)-1:0] usCnt,
  output owm_strobe_t                 strb,
  output logic                        busy,
  output logic                        done
);
  localparam int UW        = $clog2(MAX_US+1);
  localparam int RST_END   = RST_LOW_US + RST_HIGH_US;
  localparam int PRES_AT   = RST_LOW_US + PRES_SAMPLE_US;
  localparam int SLOT_END  = SLOT_US + REC_US;

  typedef enum logic [2:0] {S_IDLE, S_RST_LO, S_RST_HI, S_SLOT_LO, S_SLOT_HI} state_e;

  state_e  state, stateNxt;
  owm_op_e opReg;
  logic    bitReg;
  logic    accept, finish;
  int      lowUs;

  function automatic logic hitUs(input int n);
    return tick && (usCnt == UW'(n-1));
  endfunction

  assign accept = (state == S_IDLE) && cmdStart && (owm_op_e'(cmdOp) != OP_NONE);

  always_comb begin
    if (opReg == OP_READ) lowUs = RD_LOW_US;
    else if (bitReg)      lowUs = W1_LOW_US;
    else                  lowUs = W0_LOW_US;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    finish   = 1'b0;
    unique case (state)
      S_IDLE: if (accept) begin
        strb.clrTimer    = 1'b1;
        strb.setLow      = 1'b1;
        strb.clrPresence = (owm_op_e'(cmdOp) == OP_RESET);
        stateNxt = (owm_op_e'(cmdOp) == OP_RESET) ? S_RST_LO : S_SLOT_LO;
      end
      S_RST_LO: if (hitUs(RST_LOW_US)) begin
        strb.relLow = 1'b1;
        stateNxt    = S_RST_HI;
      end
      S_RST_HI: begin
        strb.samplePresence = hitUs(PRES_AT);
        if (hitUs(RST_END)) begin
          finish   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_SLOT_LO: if (hitUs(lowUs)) begin
        strb.relLow = 1'b1;
        stateNxt    = S_SLOT_HI;
      end
      S_SLOT_HI: begin
        strb.sampleBit = (opReg == OP_READ) && hitUs(RD_SAMPLE_US);
        if (hitUs(SLOT_END)) begin
          finish   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      opReg  <= OP_RESET;
      bitReg <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finish;
      if (accept) begin
        busy   <= 1'b1;
        opReg  <= owm_op_e'(cmdOp);
        bitReg <= cmdBit;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R6
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdStart) |=> $stable(opReg) && $stable(bitReg)); // R7
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdStart && cmdOp == 2'b11) |=> !busy); // R7
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US    = 50,
  parameter int RST_LOW_US     = 500,
  parameter int RST_HIGH_US    = 500,
  parameter int PRES_SAMPLE_US = 70,
  parameter int W1_LOW_US      = 6,
  parameter int W0_LOW_US      = 65,
  parameter int RD_LOW_US      = 2,
  parameter int RD_SAMPLE_US   = 13,
  parameter int SLOT_US        = 70,
  parameter int REC_US         = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       busIn,
  output logic       busDriveLow,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       readBit
);
  localparam int MAX_US = (RST_LOW_US + RST_HIGH_US > SLOT_US + REC_US) ?
                          RST_LOW_US + RST_HIGH_US : SLOT_US + REC_US;
  localparam int UW = $clog2(MAX_US+1);

  owm_strobe_t strb;
  logic        tick;
  logic [UW-1:0] usCnt;

  owm_ctrl #(
    .MAX_US(MAX_US), .RST_LOW_US(RST_LOW_US), .RST_HIGH_US(RST_HIGH_US),
    .PRES_SAMPLE_US(PRES_SAMPLE_US), .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US),
    .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .SLOT_US(SLOT_US), .REC_US(REC_US)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdBit(cmdBit),
    .tick(tick), .usCnt(usCnt), .strb(strb), .busy(busy), .done(done)
  );

  owm_datapath #(.CLKS_PER_US(CLKS_PER_US), .MAX_US(MAX_US)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn), .tick(tick), .usCnt(usCnt),
    .busDriveLow(busDriveLow), .presence(presence), .readBit(readBit)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busDriveLow); // R8
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> busDriveLow); // R6
endmodule

// File: tb/owm_slot_engine_tb.sv
module owm_slot_engine_tb_top;
  localparam int  C  = 2;
  localparam time US = 40ns;

  logic clk = 0, rstN = 0, cmdStart = 0, cmdBit = 0, slaveLow = 0;
  logic [1:0] cmdOp = 2'b00;
  logic busIn, busDriveLow, busy, done, presence, readBit;
  int checks = 0, failures = 0;
  int lowCnt, busyCnt, doneCnt;
  int slaveMode = 0; // 0 none,1 presence,2 early pulse,3 read low 30us,4 low 10us,5 low 16us

  always #10ns clk = ~clk;
  assign busIn = ~(busDriveLow | slaveLow);

  owm_slot_engine #(.CLKS_PER_US(C)) dut_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdBit(cmdBit),
    .busIn(busIn), .busDriveLow(busDriveLow), .busy(busy), .done(done),
    .presence(presence), .readBit(readBit)
  );

  always @(posedge busDriveLow) begin
    case (slaveMode)
      1: begin @(negedge busDriveLow); #(30*US); slaveLow = 1; #(100*US); slaveLow = 0; end
      2: begin @(negedge busDriveLow); #(10*US); slaveLow = 1; #(40*US); slaveLow = 0; end
      3: begin slaveLow = 1; #(30*US); slaveLow = 0; end
      4: begin slaveLow = 1; #(10*US); slaveLow = 0; end
      5: begin slaveLow = 1; #(16*US); slaveLow = 0; end
      default: ;
    endcase
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic b, input int injectAt);
    lowCnt = 0; busyCnt = 0; doneCnt = 0;
    @(negedge clk); cmdOp = op; cmdBit = b; cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    for (int i = 0; i < 5000; i++) begin
      lowCnt += int'(busDriveLow); busyCnt += int'(busy); doneCnt += int'(done);
      if (!busy && done) break;
      if (injectAt > 0 && busyCnt == injectAt) begin cmdOp = 2'b01; cmdBit = 0; cmdStart = 1; end
      else cmdStart = 0;
      @(negedge clk);
    end
    cmdStart = 0;
    @(negedge clk); doneCnt += int'(done);
    chk("R8 released after op", int'(busDriveLow), 0);
  endtask

  initial begin
    #(200000 * 20ns);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset drive", int'(busDriveLow), 0);
    chk("R8 reset presence", int'(presence), 0);
    chk("R8 reset readBit", int'(readBit), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 R2: reset with no slave, with answering slave, with early pulse
    for (int m = 0; m < 3; m++) begin
      slaveMode = m;
      runOp(2'b00, 0, 0);
      chk("R1 reset low cycles", lowCnt, 500*C);
      chk("R1 reset busy cycles", busyCnt, 1000*C);
      chk("R6 reset done pulses", doneCnt, 1);
      chk("R2 presence", int'(presence), (m == 1) ? 1 : 0);
    end

    // R2 presence held across write; R7 command injected while busy is ignored
    slaveMode = 1;
    runOp(2'b00, 0, 0);
    chk("R2 presence set", int'(presence), 1);
    slaveMode = 0;
    runOp(2'b01, 1, 0);
    chk("R2 presence held after write", int'(presence), 1);
    runOp(2'b00, 0, 300);
    chk("R7 busy-ignore low cycles", lowCnt, 500*C);
    chk("R7 busy-ignore busy cycles", busyCnt, 1000*C);
    chk("R2 presence cleared by new reset", int'(presence), 0);

    // R3 R4 R5 sweep over write bits and read slave responses
    for (int b = 0; b < 2; b++) begin
      runOp(2'b01, b[0], 0);
      chk("R3 write low cycles", lowCnt, (b == 1) ? 6*C : 65*C);
      chk("R4 write busy cycles", busyCnt, 71*C);
      chk("R6 write done pulses", doneCnt, 1);
    end
    for (int m = 0; m < 4; m++) begin
      slaveMode = (m == 0) ? 0 : m + 2;
      runOp(2'b10, 0, 0);
      chk("R5 read low cycles", lowCnt, 2*C);
      chk("R4 read busy cycles", busyCnt, 71*C);
      chk("R5 readBit", int'(readBit), (m == 0 || m == 2) ? 1 : 0);
    end
    slaveMode = 0;
    runOp(2'b01, 0, 60);
    chk("R7 write not extended", busyCnt, 71*C);
    chk("R5 readBit held across write", int'(readBit), 0);

    // R7 reserved op ignored
    @(negedge clk); cmdOp = 2'b11; cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    chk("R7 reserved op busy", int'(busy), 0);
    @(negedge clk);
    chk("R7 reserved op drive", int'(busDriveLow), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule